// File: doc/BRIEF.md
# Bidirectional Trigger Line Router

This block joins a set of backplane TTL trigger lines to an equal number of expansion-cable trigger lines. A single word-wide control register holds, for every line, one bit that connects the line and one bit that picks which side drives the other. A connected line passes the level of its source side to the opposite side, with that side's output-enable raised. A line that is not connected drives nothing on either side.

Both sides of every line are modelled as separate input, output and output-enable signals; the pad drivers sit outside this block. Software reaches the register over a simple bus made of an address, a write strobe, a read strobe, write data and read data. Routing follows the registered control bits combinationally, so a change on a source line shows on the destination in the same cycle.

Top module: `trig_router`

## Requirements
- R1: After reset the control register reads 0x0000 and every output-enable on both sides is low.
- R2: A write strobe with address 0x14 loads the write data into the control register at the next rising clock edge. A read strobe with address 0x14 returns the register contents in the same cycle.
- R3: A write strobe at any address other than 0x14 leaves the control register unchanged.
- R4: Read data is 0x0000 when the read strobe is low or the address is not 0x14.
- R5: Register bit 8+n is the connect bit of line n. When it is 0, both output-enables of line n are low and both outputs of line n are 0, whatever register bit n holds.
- R6: Register bit n is the direction bit of line n. With bit 8+n set and bit n clear, the expansion output-enable of line n is high, the expansion output equals the backplane input, and the backplane output-enable is low.
- R7: With bit 8+n set and bit n set, the backplane output-enable of line n is high, the backplane output equals the expansion input, and the expansion output-enable is low.
- R8: For no line are the backplane and expansion output-enables high together.
- R9: Each line is routed from its own two control bits alone, and a change on a source input reaches the destination output in the same cycle with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| bp_in | input | 8 | Backplane trigger levels seen at the pads |
| bp_out | output | 8 | Levels to drive onto the backplane lines |
| bp_oe | output | 8 | Backplane drive enables |
| xp_in | input | 8 | Expansion trigger levels seen at the pads |
| xp_out | output | 8 | Levels to drive onto the expansion lines |
| xp_oe | output | 8 | Expansion drive enables |

## Verification
The properties assume that the bus strobes and address are stable around the clock edge and that no write is issued while the internal reset is still being released, since such a write is dropped and the write-to-routing property would then disagree. The stimulus changes all inputs one time unit after a rising edge and waits several cycles after reset before its first access. Trigger inputs are driven freely, including toggles while lines are connected, because the routing properties make no assumption about them.

// File: rtl/trig_rt_pkg.sv
package trig_rt_pkg;

  typedef enum logic [1:0] {
    ROUTE_OFF   = 2'd0,
    ROUTE_BP2XP = 2'd1,
    ROUTE_XP2BP = 2'd2
  } route_e;

  function automatic route_e route_of(input logic conn, input logic dir);
    if (!conn)      return ROUTE_OFF;
    else if (!dir)  return ROUTE_BP2XP;
    else            return ROUTE_XP2BP;
  endfunction

endpackage

// File: rtl/trig_rst_sync.sv
module trig_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/trig_cfg_reg.sv
module trig_cfg_reg #(
  parameter int          LINES      = 8,
  parameter int          ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CFG_OFFSET = 8'h14,
  localparam int         CFG_W      = 2 * LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CFG_W-1:0]  bus_wdata,
  output logic [CFG_W-1:0]  bus_rdata,
  output logic [LINES-1:0]  conn,
  output logic [LINES-1:0]  dir
);
  logic             hit;
  logic             load_en;
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    hit     = (bus_addr == CFG_OFFSET);
    load_en = hit && bus_wr;
    cfg_d   = load_en ? bus_wdata : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    bus_rdata = (hit && bus_rd) ? cfg_q : '0;
    conn      = cfg_q[CFG_W-1:LINES];
    dir       = cfg_q[LINES-1:0];
  end
endmodule

// File: rtl/trig_lane.sv
module trig_lane
  import trig_rt_pkg::*;
(
  input  logic conn,
  input  logic dir,
  input  logic bp_in,
  input  logic xp_in,
  output logic bp_out,
  output logic bp_oe,
  output logic xp_out,
  output logic xp_oe
);
  route_e mode;

  always_comb begin
    mode   = route_of(conn, dir);
    bp_out = 1'b0;
    bp_oe  = 1'b0;
    xp_out = 1'b0;
    xp_oe  = 1'b0;
    unique case (mode)
      ROUTE_BP2XP: begin
        xp_out = bp_in;
        xp_oe  = 1'b1;
      end
      ROUTE_XP2BP: begin
        bp_out = xp_in;
        bp_oe  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trig_router.sv
module trig_router #(
  parameter int          LINES      = 8,
  parameter int          ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CFG_OFFSET = 8'h14,
  localparam int         CFG_W      = 2 * LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CFG_W-1:0]  bus_wdata,
  output logic [CFG_W-1:0]  bus_rdata,
  input  logic [LINES-1:0]  bp_in,
  output logic [LINES-1:0]  bp_out,
  output logic [LINES-1:0]  bp_oe,
  input  logic [LINES-1:0]  xp_in,
  output logic [LINES-1:0]  xp_out,
  output logic [LINES-1:0]  xp_oe
);
  logic             rst_sync_n;
  logic [LINES-1:0] conn;
  logic [LINES-1:0] dir;

  trig_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  trig_cfg_reg #(
    .LINES      (LINES),
    .ADDR_W     (ADDR_W),
    .CFG_OFFSET (CFG_OFFSET)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .conn      (conn),
    .dir       (dir)
  );

  for (genvar n = 0; n < LINES; n++) begin : g_lane
    trig_lane u_lane (
      .conn   (conn[n]),
      .dir    (dir[n]),
      .bp_in  (bp_in[n]),
      .xp_in  (xp_in[n]),
      .bp_out (bp_out[n]),
      .bp_oe  (bp_oe[n]),
      .xp_out (xp_out[n]),
      .xp_oe  (xp_oe[n])
    );
  end
endmodule

// File: rtl/trig_router_chk.sv
module trig_router_chk #(
  parameter int          LINES      = 8,
  parameter int          ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CFG_OFFSET = 8'h14,
  localparam int         CFG_W      = 2 * LINES
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [CFG_W-1:0]  bus_wdata,
  input logic [CFG_W-1:0]  bus_rdata,
  input logic [LINES-1:0]  bp_in,
  input logic [LINES-1:0]  bp_out,
  input logic [LINES-1:0]  bp_oe,
  input logic [LINES-1:0]  xp_in,
  input logic [LINES-1:0]  xp_out,
  input logic [LINES-1:0]  xp_oe
);
  // R2
  wr_loads_route_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == CFG_OFFSET) |=>
      (xp_oe == ($past(bus_wdata[CFG_W-1:LINES]) & ~$past(bus_wdata[LINES-1:0]))) &&
      (bp_oe == ($past(bus_wdata[CFG_W-1:LINES]) &  $past(bus_wdata[LINES-1:0]))));

  // R3
  no_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_wr && bus_addr == CFG_OFFSET) |=> ($stable(bp_oe) && $stable(xp_oe)));

  // R4
  rd_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_rd && bus_addr == CFG_OFFSET) |-> (bus_rdata == '0));

  // R8
  oe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bp_oe & xp_oe) == '0);

  // R6
  xp_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((xp_out & xp_oe) == (bp_in & xp_oe)) && ((xp_out & ~xp_oe) == '0));

  // R7
  bp_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((bp_out & bp_oe) == (xp_in & bp_oe)) && ((bp_out & ~bp_oe) == '0));

  // R5
  rd_oe_match_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && bus_addr == CFG_OFFSET) |->
      ((bus_rdata[CFG_W-1:LINES] == '0) || ((bp_oe | xp_oe) == bus_rdata[CFG_W-1:LINES])));
endmodule

bind trig_router trig_router_chk #(
  .LINES      (LINES),
  .ADDR_W     (ADDR_W),
  .CFG_OFFSET (CFG_OFFSET)
) u_chk (.*);

// File: tb/trig_router_tb.sv
module trig_router_tb;
  localparam int L = 8;
  localparam int W = 2 * L;
  localparam logic [7:0] OFF = 8'h14;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [L-1:0] bp_in = '0, bp_out, bp_oe;
  logic [L-1:0] xp_in = '0, xp_out, xp_oe;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];
  logic [W-1:0] model;

  always #2 clk = ~clk;

  trig_router u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bp_in(bp_in), .bp_out(bp_out), .bp_oe(bp_oe),
    .xp_in(xp_in), .xp_out(xp_out), .xp_oe(xp_oe)
  );

  function automatic logic [15:0] observe(int kind);
    case (kind)
      0: return bus_rdata;
      1: return {8'h00, bp_out};
      2: return {8'h00, bp_oe};
      3: return {8'h00, xp_out};
      default: return {8'h00, xp_oe};
    endcase
  endfunction

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      act = observe(it.kind);
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(int kind, logic [15:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic push_routes(string tag);
    logic [L-1:0] en, dr, xoe, boe;
    en  = model[W-1:L];
    dr  = model[L-1:0];
    xoe = en & ~dr;
    boe = en & dr;
    push(4, {8'h00, xoe}, tag);
    push(2, {8'h00, boe}, tag);
    push(3, {8'h00, bp_in & xoe}, tag);
    push(1, {8'h00, xp_in & boe}, tag);
  endtask

  task automatic bus_write(logic [7:0] a, logic [W-1:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    if (a == OFF) model = d;
  endtask

  task automatic bus_read(logic [7:0] a, logic rd, string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = rd;
    push(0, (rd && a == OFF) ? model : '0, tag);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic set_lines(logic [L-1:0] b, logic [L-1:0] x, string tag);
    @(posedge clk); #1;
    bp_in = b; xp_in = x;
    push_routes(tag);
  endtask

  initial begin
    model = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    bus_read(OFF, 1'b1, "R1");
    set_lines(8'hFF, 8'hFF, "R1");

    // R5: connect bits clear, direction bits set -> isolated
    bus_write(OFF, 16'h00FF);
    set_lines(8'hA5, 8'h5A, "R5");
    bus_read(OFF, 1'b1, "R2");

    // R6: all lines backplane to expansion
    bus_write(OFF, 16'hFF00);
    set_lines(8'hC3, 8'h00, "R6");
    set_lines(8'h3C, 8'hFF, "R6");

    // R7: all lines expansion to backplane
    bus_write(OFF, 16'hFFFF);
    set_lines(8'h00, 8'h96, "R7");
    set_lines(8'hFF, 8'h69, "R7");

    // R9 + R8: mixed per-line settings and same-cycle propagation
    bus_write(OFF, 16'hF0_3C);
    set_lines(8'hAA, 8'h55, "R9");
    set_lines(8'h55, 8'hAA, "R9");
    bus_read(OFF, 1'b1, "R2");

    // R3: write elsewhere ignored, visible through readback and routing
    bus_write(8'h10, 16'h0000);
    bus_read(OFF, 1'b1, "R3");
    set_lines(8'hFF, 8'hFF, "R3");
    bus_write(8'h15, 16'hFFFF);
    bus_read(OFF, 1'b1, "R3");

    // R4: reads elsewhere or without strobe give zero
    bus_read(8'h18, 1'b1, "R4");
    bus_read(OFF, 1'b0, "R4");

    // R8: single-line boundary, line 0 and line 7 opposite ways
    bus_write(OFF, 16'h81_80);
    set_lines(8'hFF, 8'hFF, "R8");

    @(posedge clk); @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule